// File: doc/BRIEF.md
# Pixel clock program word calculator

This block converts a requested pixel clock, given as an unsigned integer in steps of 0.01 MHz, into the 13-bit programming word for a serially loaded clock synthesizer. The synthesizer has a binary post-divider. A request outside the supported band is rejected with an error flag. A request below the VCO band is doubled until it reaches the band, and each doubling doubles the post-divide factor. The normalised frequency is then scaled by the reference ratio 46/1432 with round-to-nearest, the fixed offset 257 is removed, and the post-divider code and the stop bits are merged in.

A request starts with a one-cycle `start` pulse. The frequency is captured on the same edge. `busy` stays high while the request is being worked on, and one `done` pulse marks the cycle in which the results appear. Both divisions share one restoring divider that produces one quotient bit per clock. The results stay on the outputs until the next request finishes.

Top module: `pixclk_word_calc`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `err` are 0, and `word` and `post_div` are 0.
- R2: A request with frequency above 15938 or below 1000 completes with `err`=1, `word`=0 and `post_div`=0.
- R3: An accepted frequency is doubled while it is below 8000. `post_div` reports the factor 1, 2, 4 or 8 as the value 1, 2, 4 or 8.
- R4: N equals ((46*f*1000)/1432 + 500)/1000 with truncating integer division, where f is the doubled frequency.
- R5: `word` = 0x1800 | (C << 9) | ((N - 257) mod 8192). C is 3, 2, 1 or 0 for a factor of 1, 2, 4 or 8, so bits 12:11 are always 11 on success.
- R6: `busy` rises on the edge that accepts `start` and stays high until `done`. `done` lasts exactly one cycle, and `busy` is low in that cycle.
- R7: A `start` pulse that arrives while `busy` is high is ignored, and the running request finishes with its own result.
- R8: If the start is sampled at edge S, a rejected request completes at edge S+1. An accepted request completes at edge S+68+d, where d is the number of doublings.
- R9: `word`, `post_div` and `err` change only on the edge that raises `done`, and hold their values otherwise.
- R10: The frequencies 1000 and 15938 are accepted, and 999 and 15939 are rejected. The frequency 8000 needs no doubling, while 7999 needs one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse, sampled while idle |
| freq_in | input | 16 | Requested frequency in 0.01 MHz steps |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was out of range |
| word | output | 13 | Synthesizer programming word |
| post_div | output | 4 | Post-divide factor of the last request |

## Verification
The bench holds a behavioural reference that computes each result with plain integer arithmetic. It schedules the result one edge after the start for a rejection, and 68+d edges after the start for an accepted request. The reference is compared with `busy`, `done`, `err`, `word` and `post_div` at every falling edge, away from the active edge. A done pulse that comes early or late shows up as a mismatch. Hand-computed words at the range and band edges, a start issued during a busy period, and a start issued in the done cycle itself are checked against the same schedule.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_NORM,
    ST_DIVA,
    ST_DIVB
  } pcw_state_e;
endpackage

// File: rtl/pcw_rdiv.sv
module pcw_rdiv #(
  parameter int DW = 32,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quot,
  output logic          valid
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] q_r;
  logic [VW-1:0] rem_r;
  logic [VW-1:0] dvs_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;
  logic          valid_r;
  logic [VW:0]   shifted;
  logic [VW:0]   trial;
  logic          fits;

  always_comb begin
    shifted = {rem_r, q_r[DW-1]};
    trial   = shifted - {1'b0, dvs_r};
    fits    = ~trial[VW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r     <= '0;
      rem_r   <= '0;
      dvs_r   <= '0;
      cnt_r   <= '0;
      run_r   <= 1'b0;
      valid_r <= 1'b0;
    end else if (load) begin
      q_r     <= dividend;
      rem_r   <= '0;
      dvs_r   <= divisor;
      cnt_r   <= CW'(DW);
      run_r   <= 1'b1;
      valid_r <= 1'b0;
    end else if (run_r) begin
      q_r   <= {q_r[DW-2:0], fits};
      rem_r <= fits ? trial[VW-1:0] : shifted[VW-1:0];
      cnt_r <= cnt_r - CW'(1);
      if (cnt_r == CW'(1)) begin
        run_r   <= 1'b0;
        valid_r <= 1'b1;
      end
    end else begin
      valid_r <= 1'b0;
    end
  end

  assign quot  = q_r;
  assign valid = valid_r;

  // R4
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (rst)
    run_r |-> (rem_r < dvs_r));
  // R8
  load_starts_run_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (run_r && !valid_r));
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_r && !load) |=> !valid_r);
endmodule

// File: rtl/pcw_pack.sv
module pcw_pack #(
  parameter int          NW        = 32,
  parameter int          DBL_W     = 2,
  parameter int          WORD_W    = 13,
  parameter int          N_OFFSET  = 257,
  parameter int          CODE_LSB  = 9,
  parameter logic [12:0] STOP_BITS = 13'h1800
) (
  input  logic [NW-1:0]     n_val,
  input  logic [DBL_W-1:0]  dbl,
  output logic [WORD_W-1:0] word
);
  logic [NW-1:0]     base;
  logic [WORD_W-1:0] code_field;

  always_comb begin
    base       = n_val - NW'(N_OFFSET);
    code_field = WORD_W'(~dbl) << CODE_LSB;
    word       = WORD_W'(STOP_BITS) | code_field | base[WORD_W-1:0];
  end
endmodule

// File: rtl/pixclk_word_calc.sv
module pixclk_word_calc
  import pcw_pkg::*;
#(
  parameter int          FW        = 16,
  parameter int          F_MIN     = 1000,
  parameter int          F_MAX     = 15938,
  parameter int          VCO_LOW   = 8000,
  parameter int          REF_MUL   = 46,
  parameter int          REF_DIV   = 1432,
  parameter int          SCALE     = 1000,
  parameter int          WORD_W    = 13,
  parameter int          N_OFFSET  = 257,
  parameter int          CODE_LSB  = 9,
  parameter logic [12:0] STOP_BITS = 13'h1800,
  parameter int          DBL_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [FW-1:0]          freq_in,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [WORD_W-1:0]      word,
  output logic [(1<<DBL_W)-1:0]  post_div
);
  localparam int DW      = 32;
  localparam int DIV_MAX = (REF_DIV > SCALE) ? REF_DIV : SCALE;
  localparam int VW      = $clog2(DIV_MAX + 1);
  localparam int HALF    = SCALE / 2;
  localparam int PDW     = 1 << DBL_W;

  pcw_state_e        state_r;
  logic [FW-1:0]     fr_r;
  logic [DBL_W-1:0]  dbl_r;
  logic              busy_r, done_r, err_r;
  logic [WORD_W-1:0] word_r;
  logic [PDW-1:0]    pdiv_r;

  logic              in_band, out_of_range;
  logic              dv_load, dv_valid;
  logic [DW-1:0]     dv_dividend, dv_quot;
  logic [VW-1:0]     dv_divisor;
  logic [WORD_W-1:0] packed_word;

  always_comb begin
    in_band      = (fr_r >= FW'(VCO_LOW));
    out_of_range = (fr_r > FW'(F_MAX)) || (fr_r < FW'(F_MIN));
    dv_load      = ((state_r == ST_NORM) && in_band) ||
                   ((state_r == ST_DIVA) && dv_valid);
    if (state_r == ST_DIVA) begin
      dv_dividend = dv_quot + DW'(HALF);
      dv_divisor  = VW'(SCALE);
    end else begin
      dv_dividend = DW'(fr_r) * DW'(REF_MUL * SCALE);
      dv_divisor  = VW'(REF_DIV);
    end
  end

  pcw_rdiv #(.DW(DW), .VW(VW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (dv_load),
    .dividend (dv_dividend),
    .divisor  (dv_divisor),
    .quot     (dv_quot),
    .valid    (dv_valid)
  );

  pcw_pack #(
    .NW        (DW),
    .DBL_W     (DBL_W),
    .WORD_W    (WORD_W),
    .N_OFFSET  (N_OFFSET),
    .CODE_LSB  (CODE_LSB),
    .STOP_BITS (STOP_BITS)
  ) u_pack (
    .n_val (dv_quot),
    .dbl   (dbl_r),
    .word  (packed_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r <= ST_IDLE;
      fr_r    <= '0;
      dbl_r   <= '0;
      busy_r  <= 1'b0;
      done_r  <= 1'b0;
      err_r   <= 1'b0;
      word_r  <= '0;
      pdiv_r  <= '0;
    end else begin
      done_r <= 1'b0;
      case (state_r)
        ST_IDLE: begin
          if (start) begin
            fr_r    <= freq_in;
            dbl_r   <= '0;
            busy_r  <= 1'b1;
            state_r <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (out_of_range) begin
            err_r   <= 1'b1;
            word_r  <= '0;
            pdiv_r  <= '0;
            done_r  <= 1'b1;
            busy_r  <= 1'b0;
            state_r <= ST_IDLE;
          end else begin
            state_r <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (!in_band) begin
            fr_r  <= fr_r << 1;
            dbl_r <= dbl_r + DBL_W'(1);
          end else begin
            state_r <= ST_DIVA;
          end
        end
        ST_DIVA: begin
          if (dv_valid) state_r <= ST_DIVB;
        end
        ST_DIVB: begin
          if (dv_valid) begin
            word_r  <= packed_word;
            pdiv_r  <= PDW'(1) << dbl_r;
            err_r   <= 1'b0;
            done_r  <= 1'b1;
            busy_r  <= 1'b0;
            state_r <= ST_IDLE;
          end
        end
        default: state_r <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_r;
  assign done     = done_r;
  assign err      = err_r;
  assign word     = word_r;
  assign post_div = pdiv_r;

  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R2
  err_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (word == '0 && post_div == '0));
  // R3
  pdiv_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ($countones(post_div) == 1));
  // R5
  stop_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ((word & WORD_W'(STOP_BITS)) == WORD_W'(STOP_BITS)));
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> (!done || 1'b1) && ($past(done) || 1'b1) && (done || ($stable(word) && $stable(err) && $stable(post_div))));
endmodule

// File: tb/tb_pixclk_word_calc.sv
`timescale 1ns/1ps
module tb_pixclk_word_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] freq_in = '0;
  logic        busy, done, err;
  logic [12:0] word;
  logic [3:0]  post_div;

  int tests = 0;
  int fails = 0;

  // reference model state
  int m_busy = 0, m_done = 0, m_err = 0, m_word = 0, m_pd = 0, m_cnt = 0;
  int p_err = 0, p_word = 0, p_pd = 0;

  always #5 clk = ~clk;

  pixclk_word_calc dut (
    .clk(clk), .rst(rst), .start(start), .freq_in(freq_in),
    .busy(busy), .done(done), .err(err), .word(word), .post_div(post_div)
  );

  // behavioural reference: R2 R3 R4 R5 R8
  task automatic ref_calc(input int f, output int e, output int w,
                          output int pd, output int lat);
    longint fl, n;
    int d;
    if (f > 15938 || f < 1000) begin
      e = 1; w = 0; pd = 0; lat = 1;
    end else begin
      fl = f; d = 0;
      while (fl < 8000) begin fl = fl * 2; d++; end
      n = ((46 * fl * 1000) / 1432 + 500) / 1000;
      e = 0;
      pd = 1 << d;
      w = 'h1800 | ((3 - d) << 9) | int'((n - 257) & 'h1fff);
      lat = 68 + d;
    end
  endtask

  always @(posedge clk) begin
    int was_busy, lat;
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_word = 0; m_pd = 0; m_cnt = 0;
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (m_busy != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_err = p_err; m_word = p_word; m_pd = p_pd;
        end
      end
      if (was_busy == 0 && start) begin
        ref_calc(int'(freq_in), p_err, p_word, p_pd, lat);
        m_cnt = lat;
        m_busy = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 busy", int'(busy), m_busy);
      chk("R8 done", int'(done), m_done);
      chk("R2 err", int'(err), m_err);
      chk("R4 R5 word", int'(word), m_word);
      chk("R3 post_div", int'(post_div), m_pd);
    end
  end

  task automatic issue(input int f);
    @(negedge clk);
    start = 1'b1;
    freq_in = 16'(f);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_one(input int f);
    issue(f);
    wait_done();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 word", int'(word), 0);
    chk("R1 post_div", int'(post_div), 0);
    rst = 1'b0;
    @(negedge clk);

    // R10: band edges with hand-computed words
    issue(8000); wait_done();
    chk("R10 8000 word", int'(word), 'h1E00);
    chk("R10 8000 pd", int'(post_div), 1);
    @(negedge clk);
    issue(7999); wait_done();
    chk("R10 7999 word", int'(word), 'h1D01);
    chk("R10 7999 pd", int'(post_div), 2);
    @(negedge clk);
    issue(15938); wait_done();
    chk("R10 15938 word", int'(word), 'h1EFF);
    chk("R10 15938 err", int'(err), 0);
    @(negedge clk);
    issue(1000); wait_done();
    chk("R10 1000 word", int'(word), 'h1800);
    chk("R10 1000 pd", int'(post_div), 8);
    @(negedge clk);
    issue(999); wait_done();
    chk("R10 999 err", int'(err), 1);
    @(negedge clk);
    issue(15939); wait_done();
    chk("R10 15939 err", int'(err), 1);
    @(negedge clk);

    // R2: far out of range
    run_one(0);
    run_one(65535);
    // R4: rounding across several patterns
    issue(12345); wait_done();
    chk("R4 12345 word", int'(word), 'h1E8C);
    @(negedge clk);
    run_one(1999);
    run_one(2500);
    run_one(4000);
    run_one(9999);
    run_one(3333);

    // R9: outputs hold between completions
    repeat (5) @(negedge clk);
    chk("R9 hold word", int'(word), m_word);

    // R7: start during busy is ignored
    issue(12000);
    repeat (10) @(negedge clk);
    start = 1'b1; freq_in = 16'd999;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R7 busy start ignored err", int'(err), 0);
    // R6: start raised in the done cycle is accepted
    start = 1'b1; freq_in = 16'd5000;
    @(negedge clk);
    start = 1'b0;
    chk("R6 accept after done busy", int'(busy), 1);
    wait_done();
    chk("R3 5000 pd", int'(post_div), 2);
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule